// File: doc/BRIEF.md
# Memory Data-Line Test Sequencer

This block checks the data wires between a chip and an external word-wide memory for wires that are shorted together or left open. A single pulse on `start` runs a fixed series of test words against one base word. For each test word the sequencer writes the word to the base location, then writes a fixed decoy word to the next location up, then reads the base location back once and compares it. The decoy write puts a different charge on the data bus, so a floating wire cannot hand back the value that was just written and fake a pass.

The memory side is a plain synchronous port. A request is accepted in the cycle it is asserted. A read returns its data one or more cycles later, marked by a valid strobe. When the series ends, `done` rises and stays high. `fail` reports whether any comparison differed. The first bad test word's index, its expected value and the value actually read stay on the report outputs until the next run.

Top module: `mdl_dataline_tester`

## Requirements
- R1: While reset is applied and after it is released with no start, `busy`, `done`, `fail` and `mem_req` are all low.
- R2: For DATA_W = 2^L, test word k (0 <= k < L) has bit i equal to bit k of the index i. Test word k (L <= k < 2L) is the bitwise inverse of test word 2L-1-k. At 64 bits the sequence is AAAA..., CCCC..., F0F0..., FF00FF00..., FFFF0000FFFF0000, FFFFFFFF00000000, then 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF..., 0F0F..., 3333..., 5555....
- R3: Each test word is handled in three consecutive request cycles. The first writes the test word to the base address (`mem_we`=1). The second writes the decoy DECOY (default 0x0123456789ABCDEF) to base+1. The third reads the base address (`mem_we`=0).
- R4: The target is read exactly once per test word. The comparison uses the single value presented with `mem_rvalid`, for any read latency of one cycle or more, and no request is issued while the read is outstanding.
- R5: Any difference between the captured word and the test word sets `fail`, which stays high until the next accepted start.
- R6: After a mismatch the run still goes through all 2L test words (12 reads at 64 bits).
- R7: On the first mismatch of a run, `fail_index`, `fail_expected` and `fail_observed` capture the test-word index, the test word and the captured read data. Later mismatches in the same run leave them unchanged.
- R8: `done` rises after the last comparison and holds until the next start. An accepted start clears `done` and `fail` on the following cycle and raises `busy`.
- R9: A start pulse while `busy` is high is ignored: the running sequence and its result are unaffected.
- R10: The base address is sampled at start and used for every test word. The decoy address is base+1 modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| base_addr | input | ADDR_W | Word address of the target location |
| mem_req | output | 1 | Memory request, accepted in the same cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, meaningful with mem_rvalid |
| mem_rvalid | input | 1 | Read data valid strobe |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | Sticky mismatch flag for the run |
| fail_index | output | IDX_W | Index of the first failing test word |
| fail_expected | output | DATA_W | Test word of the first failure |
| fail_observed | output | DATA_W | Data read back at the first failure |

## Verification
The in-line checks assume that the memory raises `mem_rvalid` only while a read is outstanding, exactly once per read request, and never in the same cycle as the request. The bench memory model follows this by counting down a random latency of one to four cycles from the read request and pulsing the strobe once. It also models stuck-at-0, stuck-at-1 and floating lanes. A floating lane returns whatever last crossed the bus, so only the decoy write stands between a broken lane and a false pass. Random fault masks, base addresses and latencies are mixed with directed cases for address wrap, a late-sequence failure and a start pulse during a run.

// File: rtl/mdl_pkg.sv
package mdl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WR_PAT   = 3'd1,
      ST_WR_DECOY = 3'd2,
      ST_RD_REQ   = 3'd3,
      ST_RD_WAIT  = 3'd4,
      ST_DONE     = 3'd5
   } seq_state_e;

endpackage

// File: rtl/mdl_pattern_gen.sv
module mdl_pattern_gen #(
   parameter int DATA_W = 64,
   parameter int LANES  = $clog2(DATA_W),
   parameter int IDX_W  = $clog2(2 * LANES)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] pattern
);
   localparam int NUM_PAT = 2 * LANES;
   localparam int KW      = (LANES > 1) ? $clog2(LANES) : 1;

   logic          inv;
   logic [KW-1:0] k;

   // second half: inverses paired in reverse order
   assign inv = (idx >= IDX_W'(LANES));
   assign k   = inv ? KW'(IDX_W'(NUM_PAT - 1) - idx) : KW'(idx);

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         localparam logic [LANES-1:0] POS = LANES'(b);
         assign pattern[b] = POS[k] ^ inv;
      end
   endgenerate

endmodule

// File: rtl/mdl_fail_capture.sv
module mdl_fail_capture #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cmp_en,
   input  logic [IDX_W-1:0]  cmp_idx,
   input  logic [DATA_W-1:0] cmp_expected,
   input  logic [DATA_W-1:0] cmp_observed,
   output logic              fail,
   output logic [IDX_W-1:0]  fail_index,
   output logic [DATA_W-1:0] fail_expected,
   output logic [DATA_W-1:0] fail_observed
);
   logic mismatch;
   assign mismatch = cmp_en && (cmp_expected != cmp_observed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail          <= 1'b0;
         fail_index    <= '0;
         fail_expected <= '0;
         fail_observed <= '0;
      end else if (clear) begin
         fail          <= 1'b0;
         fail_index    <= '0;
         fail_expected <= '0;
         fail_observed <= '0;
      end else if (mismatch && !fail) begin
         fail          <= 1'b1;
         fail_index    <= cmp_idx;
         fail_expected <= cmp_expected;
         fail_observed <= cmp_observed;
      end
   end

   assert_mismatch_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mismatch && !clear) |=> fail);
   assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> fail);
   assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> ($stable(fail_index) && $stable(fail_expected) && $stable(fail_observed)));

endmodule

// File: rtl/mdl_dataline_tester.sv
module mdl_dataline_tester #(
   parameter int                DATA_W = 64,
   parameter int                ADDR_W = 16,
   parameter logic [DATA_W-1:0] DECOY  = DATA_W'(64'h0123456789ABCDEF),
   parameter int                IDX_W  = $clog2(2 * $clog2(DATA_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [IDX_W-1:0]  fail_index,
   output logic [DATA_W-1:0] fail_expected,
   output logic [DATA_W-1:0] fail_observed
);
   import mdl_pkg::*;

   localparam int LANES   = $clog2(DATA_W);
   localparam int NUM_PAT = 2 * LANES;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 8");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (IDX_W < $clog2(NUM_PAT)) begin : g_bad_idx
         $error("IDX_W too narrow for the pattern count");
      end
   endgenerate

   seq_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] pattern;
   logic              accept;
   logic              cmp_en;
   logic              last_pat;

   assign accept   = start && (state == ST_IDLE || state == ST_DONE);
   assign cmp_en   = (state == ST_RD_WAIT) && mem_rvalid;
   assign last_pat = (idx == IDX_W'(NUM_PAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         base_q <= '0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  state  <= ST_WR_PAT;
                  idx    <= '0;
                  base_q <= base_addr;
               end
            end
            ST_WR_PAT:   state <= ST_WR_DECOY;
            ST_WR_DECOY: state <= ST_RD_REQ;
            ST_RD_REQ:   state <= ST_RD_WAIT;
            ST_RD_WAIT: begin
               if (mem_rvalid) begin
                  if (last_pat) begin
                     state <= ST_DONE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_WR_PAT;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = base_q;
      mem_wdata = pattern;
      case (state)
         ST_WR_PAT: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         ST_WR_DECOY: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ADDR_W'(base_q + 1'b1);
            mem_wdata = DECOY;
         end
         ST_RD_REQ: mem_req = 1'b1;
         default: ;
      endcase
   end

   assign busy = (state != ST_IDLE) && (state != ST_DONE);
   assign done = (state == ST_DONE);

   mdl_pattern_gen #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .IDX_W  (IDX_W)
   ) u_pat (
      .idx     (idx),
      .pattern (pattern)
   );

   mdl_fail_capture #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_cap (
      .clk           (clk),
      .rst_n         (rst_n),
      .clear         (accept),
      .cmp_en        (cmp_en),
      .cmp_idx       (idx),
      .cmp_expected  (pattern),
      .cmp_observed  (mem_rdata),
      .fail          (fail),
      .fail_index    (fail_index),
      .fail_expected (fail_expected),
      .fail_observed (fail_observed)
   );

   assert_decoy_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && state == ST_WR_PAT) |=>
         (mem_req && mem_we && mem_wdata == DECOY && mem_addr == ADDR_W'(base_q + 1'b1)));
   assert_read_after_decoy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_wdata == DECOY && state == ST_WR_DECOY) |=> (mem_req && !mem_we));
   assert_quiet_while_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_WAIT) |-> !mem_req);
   assert_rvalid_expected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> (state == ST_RD_WAIT));
   assert_read_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr == base_q));
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (busy && !done && !fail));
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !cmp_en) |=> (busy && $stable(base_q) && $stable(idx)));

endmodule

// File: tb/tb_mdl_dataline_tester.sv
`timescale 1ns/1ps
module tb_mdl_dataline_tester;
   localparam int DW = 64;
   localparam int AW = 16;
   localparam int IW = 4;
   localparam logic [63:0] DECOY_V = 64'h0123456789ABCDEF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_rvalid = 1'b0;
   logic          busy, done, fail;
   logic [IW-1:0] fail_index;
   logic [DW-1:0] fail_expected, fail_observed;

   always #2.5 clk = ~clk;

   mdl_dataline_tester dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .busy(busy), .done(done),
      .fail(fail), .fail_index(fail_index), .fail_expected(fail_expected),
      .fail_observed(fail_observed));

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   // memory model state and fault masks
   logic [DW-1:0] mem [16];
   logic [DW-1:0] last_bus;
   logic [DW-1:0] float_m, s0_m, s1_m;
   logic [AW-1:0] run_base;
   int lat_max = 1;
   int cnt = 0;
   logic [DW-1:0] rd_val;
   int op_cnt, rd_cnt;
   bit seq_err;

   function automatic logic [63:0] pat(int k);
      case (k)
         0: return 64'hAAAAAAAAAAAAAAAA;   1: return 64'hCCCCCCCCCCCCCCCC;
         2: return 64'hF0F0F0F0F0F0F0F0;   3: return 64'hFF00FF00FF00FF00;
         4: return 64'hFFFF0000FFFF0000;   5: return 64'hFFFFFFFF00000000;
         6: return 64'h00000000FFFFFFFF;   7: return 64'h0000FFFF0000FFFF;
         8: return 64'h00FF00FF00FF00FF;   9: return 64'h0F0F0F0F0F0F0F0F;
         10: return 64'h3333333333333333;  default: return 64'h5555555555555555;
      endcase
   endfunction

   function automatic logic [63:0] model_obs(int k);
      logic [63:0] v;
      v = (pat(k) & ~float_m) | (DECOY_V & float_m);
      return (v & ~s0_m) | s1_m;
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model, acts on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            mem_rvalid = 1'b0;
            cnt = 0;
         end else begin
            mem_rvalid = 1'b0;
            if (cnt > 0) begin
               cnt--;
               if (cnt == 0) begin
                  mem_rvalid = 1'b1;
                  mem_rdata  = rd_val;
               end
            end
            if (mem_req) begin
               int k, ph;
               k  = op_cnt / 3;
               ph = op_cnt % 3;
               if (k >= 12) seq_err = 1;
               else if (ph == 0 && !(mem_we && mem_addr == run_base && mem_wdata == pat(k))) seq_err = 1;
               else if (ph == 1 && !(mem_we && mem_addr == AW'(run_base + 1'b1) && mem_wdata == DECOY_V)) seq_err = 1;
               else if (ph == 2 && !(!mem_we && mem_addr == run_base)) seq_err = 1;
               op_cnt++;
               if (mem_we) begin
                  mem[mem_addr[3:0]] = mem_wdata;
                  last_bus = mem_wdata;
               end else begin
                  rd_cnt++;
                  rd_val = (((mem[mem_addr[3:0]] & ~float_m) | (last_bus & float_m)) & ~s0_m) | s1_m;
                  cnt = 1 + int'($urandom % lat_max);
               end
            end
         end
      end
   end

   task automatic run_test(string name, logic [AW-1:0] b, logic [63:0] fm, logic [63:0] z0,
                           logic [63:0] o1, int lm, bit mid_start);
      int first;
      int guard;
      logic [IW-1:0] hi;
      logic [63:0] he, ho;
      float_m = fm; s0_m = z0; s1_m = o1; lat_max = lm;
      run_base = b; op_cnt = 0; rd_cnt = 0; seq_err = 0;
      for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
      last_bus = {$urandom, $urandom};
      base_addr = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base_addr = ~b;
      check(busy && !done && !fail, {"R8 start clears ", name}, {61'd0, busy, done, fail}, 64'd4);
      if (mid_start) begin
         repeat (7) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      first = -1;
      for (int k = 11; k >= 0; k--) if (model_obs(k) != pat(k)) first = k;
      check(fail == (first >= 0), {"R5 fail flag ", name}, 64'(fail), 64'(first >= 0));
      if (first >= 0) begin
         check(fail_index == IW'(first), {"R7 index ", name}, 64'(fail_index), 64'(first));
         check(fail_expected == pat(first), {"R7 expected ", name}, fail_expected, pat(first));
         check(fail_observed == model_obs(first), {"R7 observed ", name}, fail_observed, model_obs(first));
      end
      check(!seq_err && op_cnt == 36, {"R2 R3 R10 request order ", name}, 64'(op_cnt), 64'd36);
      check(rd_cnt == 12, {"R4 R6 read count ", name}, 64'(rd_cnt), 64'd12);
      if (mid_start) check(done && !seq_err, {"R9 mid-run start ignored ", name}, 64'(seq_err), 64'd0);
      hi = fail_index; he = fail_expected; ho = fail_observed;
      repeat (4) @(negedge clk);
      check(done && !busy, {"R8 done held ", name}, {62'd0, done, busy}, 64'd2);
      check(fail_index == hi && fail_expected == he && fail_observed == ho,
            {"R7 report stable ", name}, fail_observed, ho);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      float_m = '0; s0_m = '0; s1_m = '0; run_base = '0; last_bus = '0;
      op_cnt = 0; rd_cnt = 0; seq_err = 0; rd_val = '0;
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      check(!busy && !done && !fail && !mem_req, "R1 in reset", {60'd0, busy, done, fail, mem_req}, 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !done && !fail && !mem_req, "R1 after reset", {60'd0, busy, done, fail, mem_req}, 64'd0);

      run_test("clean", 16'h0000, '0, '0, '0, 1, 0);
      run_test("stuck1 bit15", 16'h0005, '0, '0, 64'h8000, 3, 0);
      run_test("floating lane", 16'h1234, 64'h0000FF0000000000, '0, '0, 4, 0);
      run_test("wrap stuck0 bit0", 16'hFFFF, '0, 64'h1, '0, 2, 1);
      run_test("clean after fail", 16'h0AB7, '0, '0, '0, 4, 0);
      for (int r = 0; r < 12; r++) begin
         logic [63:0] fm, z0, o1;
         int sh;
         sh = 8 * int'($urandom % 8);
         fm = ($urandom % 3 == 0) ? (64'hFF << sh) : '0;
         z0 = ($urandom % 3 == 0) ? (64'h1 << ($urandom % 64)) : '0;
         o1 = ($urandom % 3 == 0) ? (64'h1 << ($urandom % 64)) : '0;
         run_test($sformatf("random %0d", r), AW'($urandom), fm, z0, o1,
                  1 + int'($urandom % 4), ($urandom % 4) == 0);
      end
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule